// File: doc/BRIEF.md
# Cyclic Rung Scan Sequencer

This block schedules a ladder-style control program the way a cyclic controller runs it. A location register walks a fixed list of rung slots, one step per clock. An external evaluator computes the boolean result of the rung at the current location and returns it on `rung_res`. A slot that holds a jump redirects the walk to its target when its rung result is true. A slot that holds timer function blocks spends extra steps so that each timer can be updated before the rung itself is evaluated. The last location is the end-of-cycle point. There the block samples the physical inputs into a held image, which stays constant for the next scan. It also latches the evaluator's output image to the environment and refreshes the edge memories behind the rising-edge contacts.

The walk is controlled by three named states. `SEQ_TMR` is a timer update step: the location is held, the evaluation flag is low, and `tmr_idx` names the timer being updated. `SEQ_RUNG` is a rung evaluation step, in which the location advances. `SEQ_EOC` is the end-of-cycle location. There are three transitions. TMR_NEXT moves from `SEQ_TMR` to `SEQ_TMR` with the next timer index. TMR_DONE moves from `SEQ_TMR` to `SEQ_RUNG` after the last timer of the slot. ADVANCE moves from `SEQ_RUNG` or `SEQ_EOC` into the entry state of the new location: `SEQ_EOC` for the last location, `SEQ_TMR` for a slot with timers, and `SEQ_RUNG` otherwise. The jump table and the per-slot timer counts are parameters. By default there are 13 locations (0 to 12). Jumps go from slot 0 to 8, 1 to 10, 7 to 12 and 9 to 12. Slot 4 holds one timer and slot 6 holds two.

Top module: `scan_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the location to 0. It drives `eval_flag`, `tmr_step`, `eoc` and `rise_edge` low and `out_phys` to zero, and loads both `in_held` and the edge memories with the current `in_raw`.
- R2: In `SEQ_RUNG`, the next location is the current one plus one, unless the slot has a jump and `rung_res` is 1. A true result in a slot without a jump (for example slot 2) still advances by one.
- R3: In `SEQ_RUNG`, a slot with a jump and `rung_res` = 1 moves to its target. With the defaults these are 0 to 8, 1 to 10, 7 to 12 and 9 to 12.
- R4: `eoc` is high exactly while the location is 12 (the last location), and the next location after it is 0.
- R5: `in_held` loads `in_raw` only at the clock edge where `eoc` is high, and it keeps its value for the rest of the scan. `in_latch_en` is high exactly when `eoc` is high.
- R6: `out_phys` loads `out_img` only at the clock edge where `eoc` is high. `out_latch_en` is high exactly when `eoc` is high.
- R7: A slot with n timers (1 to 3) stays at its location for n steps with `tmr_step` high and `tmr_idx` counting 0 to n-1 in order. It then takes one rung step with `eval_flag` high before it advances.
- R8: `eval_flag` is low on every step of a slot without timers, and it is low again on the step after any advance.
- R9: `rise_edge[i]` = `in_held[i]` AND NOT memory[i]. Each memory loads the value `in_held` had just before the end-of-cycle edge, so a bit that rose during a scan shows a rising edge for exactly one following scan.
- R10: `rung_res` is ignored during timer update steps: a true result there neither moves the location nor takes a jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rung_res | input | 1 | Result of the rung at the current location |
| in_raw | input | IN_W | Physical input values |
| out_img | input | OUT_W | Output image produced by the evaluator |
| loc | output | LOC_W | Current control location |
| eval_flag | output | 1 | High on the rung step of a slot that holds timers |
| tmr_step | output | 1 | High on a timer update step |
| tmr_idx | output | TMR_W | Index of the timer being updated in this slot |
| eoc | output | 1 | End-of-cycle strobe |
| in_latch_en | output | 1 | Input sampling enable |
| out_latch_en | output | 1 | Output latching enable |
| in_held | output | IN_W | Input image held for the current scan |
| rise_edge | output | IN_W | Rising-edge contact values |
| out_phys | output | OUT_W | Outputs latched to the environment |

## Verification
The walk is run under three rung-result patterns. With all results false, the bench sees the plain order, the one-step and two-step timer slots and the wrap. With results true in jump slots, it shows that each target is taken. With results true in a slot without a jump and during a timer step, it shows that a true result alone never redirects the walk. Input patterns that change mid-scan separate sampling at end of cycle from sampling at any other step. A bit that rises, stays up and then falls shows that the rising edge lasts exactly one scan.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
    typedef enum logic [1:0] {
        SEQ_TMR  = 2'd0,
        SEQ_RUNG = 2'd1,
        SEQ_EOC  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/scan_loc_fsm.sv
`timescale 1ns/1ps
module scan_loc_fsm
    import scan_pkg::*;
#(
    parameter int NUM_LOC = 13,
    parameter int LOC_W   = $clog2(NUM_LOC),
    parameter int TMR_W   = 2,
    parameter logic [NUM_LOC-1:0]       JMP_EN  = 13'h0283,
    parameter logic [NUM_LOC*LOC_W-1:0] JMP_TGT = 52'h000C0C00000A8,
    parameter logic [NUM_LOC*TMR_W-1:0] TMR_CNT = 26'h0002100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rung_res,
    output logic [LOC_W-1:0] loc,
    output seq_state_t       state,
    output logic [TMR_W-1:0] tmr_idx,
    output logic             tmr_slot
);
    localparam logic [LOC_W-1:0] LAST = LOC_W'(NUM_LOC - 1);

    function automatic logic [TMR_W-1:0] timers_at(input logic [LOC_W-1:0] l);
        return TMR_CNT[int'(l)*TMR_W +: TMR_W];
    endfunction

    function automatic seq_state_t entry_state(input logic [LOC_W-1:0] l);
        if (l == LAST)                return SEQ_EOC;
        else if (timers_at(l) != '0)  return SEQ_TMR;
        else                          return SEQ_RUNG;
    endfunction

    logic [LOC_W-1:0] loc_nx, tgt;
    logic [TMR_W-1:0] idx_nx;
    seq_state_t       st_nx;
    logic             adv;

    always_comb begin
        loc_nx = loc;
        st_nx  = state;
        idx_nx = tmr_idx;
        adv    = 1'b0;
        tgt    = '0;
        unique case (state)
            SEQ_TMR: begin
                if (tmr_idx + 1'b1 == timers_at(loc)) st_nx  = SEQ_RUNG;   // TMR_DONE
                else                                  idx_nx = tmr_idx + 1'b1; // TMR_NEXT
            end
            SEQ_RUNG: begin
                adv = 1'b1;
                if (JMP_EN[loc] && rung_res) tgt = JMP_TGT[int'(loc)*LOC_W +: LOC_W];
                else                         tgt = loc + 1'b1;
            end
            SEQ_EOC: begin
                adv = 1'b1;
                tgt = '0;
            end
            default: begin
                adv = 1'b1;
                tgt = '0;
            end
        endcase
        if (adv) begin                                                 // ADVANCE
            loc_nx = tgt;
            st_nx  = entry_state(tgt);
            idx_nx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loc     <= '0;
            state   <= entry_state('0);
            tmr_idx <= '0;
        end else begin
            loc     <= loc_nx;
            state   <= st_nx;
            tmr_idx <= idx_nx;
        end
    end

    assign tmr_slot = (timers_at(loc) != '0);
endmodule

// File: rtl/scan_edge_bank.sv
`timescale 1ns/1ps
module scan_edge_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eoc,
    input  logic [WIDTH-1:0] in_raw,
    output logic [WIDTH-1:0] in_held,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] mem;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                in_held[i] <= in_raw[i];
                mem[i]     <= in_raw[i];
            end else if (eoc) begin
                in_held[i] <= in_raw[i];
                mem[i]     <= in_held[i];
            end
        end
        assign rise[i] = in_held[i] & ~mem[i];
    end
endmodule

// File: rtl/scan_out_latch.sv
`timescale 1ns/1ps
module scan_out_latch #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eoc,
    input  logic [WIDTH-1:0] out_img,
    output logic [WIDTH-1:0] out_phys
);
    always_ff @(posedge clk) begin
        if (rst)      out_phys <= '0;
        else if (eoc) out_phys <= out_img;
    end
endmodule

// File: rtl/scan_sequencer.sv
`timescale 1ns/1ps
module scan_sequencer
    import scan_pkg::*;
#(
    parameter int NUM_LOC = 13,
    parameter int LOC_W   = $clog2(NUM_LOC),
    parameter int TMR_W   = 2,
    parameter int IN_W    = 4,
    parameter int OUT_W   = 3,
    parameter logic [NUM_LOC-1:0]       JMP_EN  = 13'h0283,
    parameter logic [NUM_LOC*LOC_W-1:0] JMP_TGT = 52'h000C0C00000A8,
    parameter logic [NUM_LOC*TMR_W-1:0] TMR_CNT = 26'h0002100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rung_res,
    input  logic [IN_W-1:0]  in_raw,
    input  logic [OUT_W-1:0] out_img,
    output logic [LOC_W-1:0] loc,
    output logic             eval_flag,
    output logic             tmr_step,
    output logic [TMR_W-1:0] tmr_idx,
    output logic             eoc,
    output logic             in_latch_en,
    output logic             out_latch_en,
    output logic [IN_W-1:0]  in_held,
    output logic [IN_W-1:0]  rise_edge,
    output logic [OUT_W-1:0] out_phys
);
    seq_state_t state;
    logic       tmr_slot;

    scan_loc_fsm #(
        .NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .TMR_W(TMR_W),
        .JMP_EN(JMP_EN), .JMP_TGT(JMP_TGT), .TMR_CNT(TMR_CNT)
    ) u_fsm (
        .clk(clk), .rst(rst), .rung_res(rung_res),
        .loc(loc), .state(state), .tmr_idx(tmr_idx), .tmr_slot(tmr_slot)
    );

    always_comb begin
        eoc          = (state == SEQ_EOC);
        tmr_step     = (state == SEQ_TMR);
        eval_flag    = (state == SEQ_RUNG) && tmr_slot;
        in_latch_en  = eoc;
        out_latch_en = eoc;
    end

    scan_edge_bank #(.WIDTH(IN_W)) u_edge (
        .clk(clk), .rst(rst), .eoc(eoc), .in_raw(in_raw),
        .in_held(in_held), .rise(rise_edge)
    );

    scan_out_latch #(.WIDTH(OUT_W)) u_out (
        .clk(clk), .rst(rst), .eoc(eoc), .out_img(out_img), .out_phys(out_phys)
    );
endmodule

// File: rtl/scan_sequencer_chk.sv
`timescale 1ns/1ps
module scan_sequencer_chk #(
    parameter int NUM_LOC = 13,
    parameter int LOC_W   = 4,
    parameter int IN_W    = 4,
    parameter int OUT_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [LOC_W-1:0] loc,
    input logic             eval_flag,
    input logic             tmr_step,
    input logic             eoc,
    input logic [IN_W-1:0]  in_held,
    input logic [OUT_W-1:0] out_phys
);
    localparam logic [LOC_W-1:0] LAST = LOC_W'(NUM_LOC - 1);

    // R4
    loc_range_chk: assert property (@(posedge clk) disable iff (rst) loc <= LAST);

    // R4
    eoc_wrap_chk: assert property (@(posedge clk) disable iff (rst) eoc |=> (loc == '0));

    // R5
    in_hold_chk: assert property (@(posedge clk) disable iff (rst) !eoc |=> $stable(in_held));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst) !eoc |=> $stable(out_phys));

    // R10
    tmr_stay_chk: assert property (@(posedge clk) disable iff (rst) tmr_step |=> $stable(loc));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst) eval_flag |=> !eval_flag);
endmodule

bind scan_sequencer scan_sequencer_chk #(
    .NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .IN_W(IN_W), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst(rst), .loc(loc), .eval_flag(eval_flag), .tmr_step(tmr_step),
    .eoc(eoc), .in_held(in_held), .out_phys(out_phys)
);

// File: tb/scan_sequencer_test.sv
`timescale 1ns/1ps
module scan_sequencer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rung_res = 1'b0;
    logic [3:0] in_raw = 4'b1010;
    logic [2:0] out_img = 3'b000;
    logic [3:0] loc;
    logic       eval_flag, tmr_step, eoc, in_latch_en, out_latch_en;
    logic [1:0] tmr_idx;
    logic [3:0] in_held, rise_edge;
    logic [2:0] out_phys;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    scan_sequencer uut (
        .clk(clk), .rst(rst), .rung_res(rung_res), .in_raw(in_raw), .out_img(out_img),
        .loc(loc), .eval_flag(eval_flag), .tmr_step(tmr_step), .tmr_idx(tmr_idx),
        .eoc(eoc), .in_latch_en(in_latch_en), .out_latch_en(out_latch_en),
        .in_held(in_held), .rise_edge(rise_edge), .out_phys(out_phys)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic run_to(input int target);
        rung_res = 1'b0;
        for (int k = 0; k < 40 && int'(loc) != target; k++) tick();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        rst = 1'b0;
        chk("R1", "loc", 32'(loc), 0);
        chk("R1", "eval_flag", 32'(eval_flag), 0);
        chk("R1", "tmr_step", 32'(tmr_step), 0);
        chk("R1", "eoc", 32'(eoc), 0);
        chk("R1", "in_held", 32'(in_held), 32'hA);
        chk("R1", "out_phys", 32'(out_phys), 0);
        chk("R9", "rise_edge after reset", 32'(rise_edge), 0);
    endtask

    task automatic t_linear();
        int el[17] = '{0, 1, 2, 3, 4, 4, 5, 6, 6, 6, 7, 8, 9, 10, 11, 12, 0};
        bit ts[17] = '{0, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0};
        int ti[17] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0};
        bit fl[17] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0};
        rung_res = 1'b0;
        for (int i = 0; i < 17; i++) begin
            chk("R2", "loc in plain scan", 32'(loc), 32'(el[i]));
            chk("R7", "tmr_step", 32'(tmr_step), 32'(ts[i]));
            if (ts[i]) chk("R7", "tmr_idx", 32'(tmr_idx), 32'(ti[i]));
            chk("R8", "eval_flag", 32'(eval_flag), 32'(fl[i]));
            chk("R4", "eoc", 32'(eoc), 32'(el[i] == 12));
            if (i < 16) tick();
        end
    endtask

    task automatic t_jump();
        rung_res = 1'b1; tick();
        chk("R3", "jump 0->8", 32'(loc), 8);
        rung_res = 1'b0; tick();
        chk("R2", "8->9", 32'(loc), 9);
        rung_res = 1'b1; tick();
        chk("R3", "jump 9->12", 32'(loc), 12);
        chk("R4", "eoc at 12", 32'(eoc), 1);
        rung_res = 1'b0; tick();
        chk("R4", "wrap to 0", 32'(loc), 0);
        tick();
        rung_res = 1'b1; tick();
        chk("R3", "jump 1->10", 32'(loc), 10);
        run_to(0);
        tick(); tick();
        chk("R2", "at slot 2", 32'(loc), 2);
        rung_res = 1'b1; tick();
        chk("R2", "true result without jump 2->3", 32'(loc), 3);
        rung_res = 1'b0; tick();
        chk("R7", "slot 4 timer step", 32'(tmr_step), 1);
        rung_res = 1'b1; tick();
        chk("R10", "true result during timer step holds loc", 32'(loc), 4);
        chk("R7", "slot 4 rung step flag", 32'(eval_flag), 1);
        rung_res = 1'b0;
        run_to(7);
        rung_res = 1'b1; tick();
        chk("R3", "jump 7->12", 32'(loc), 12);
        rung_res = 1'b0; tick();
        chk("R4", "wrap after jump", 32'(loc), 0);
    endtask

    task automatic t_io();
        in_raw  = 4'b0110;
        out_img = 3'b101;
        tick(); tick();
        chk("R5", "in_held mid scan", 32'(in_held), 32'hA);
        chk("R6", "out_phys mid scan", 32'(out_phys), 0);
        run_to(12);
        chk("R5", "in_latch_en at eoc", 32'(in_latch_en), 1);
        chk("R6", "out_latch_en at eoc", 32'(out_latch_en), 1);
        chk("R5", "in_held before eoc edge", 32'(in_held), 32'hA);
        tick();
        chk("R5", "in_held after eoc", 32'(in_held), 32'h6);
        chk("R6", "out_phys after eoc", 32'(out_phys), 32'h5);
        chk("R9", "rise after 1010->0110", 32'(rise_edge), 32'h4);
        chk("R5", "in_latch_en off eoc", 32'(in_latch_en), 0);
        in_raw  = 4'b0000;
        out_img = 3'b010;
        tick(); tick(); tick();
        chk("R9", "rise held within scan", 32'(rise_edge), 32'h4);
        chk("R6", "out_phys held within scan", 32'(out_phys), 32'h5);
        run_to(12);
        tick();
        chk("R9", "rise cleared after fall", 32'(rise_edge), 0);
        chk("R6", "out_phys second latch", 32'(out_phys), 32'h2);
        in_raw = 4'b1111;
        run_to(12);
        tick();
        chk("R9", "rise 0000->1111", 32'(rise_edge), 32'hF);
        run_to(12);
        tick();
        chk("R9", "rise lasts one scan", 32'(rise_edge), 0);
    endtask

    initial begin
        t_reset();
        t_linear();
        t_jump();
        t_io();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule